// File: doc/BRIEF.md
# Edge-Aligned PWM and Compare Timer

This block is a 16-bit up-counter with a programmable wrap limit and a single channel. The channel has three uses. It can record the counter value when an input edge arrives. It can invert an output each time the counter reaches a programmed value. It can produce a high-true pulse train whose period follows the wrap limit and whose width follows the channel value. Software reaches every setting through a byte-wide write port and a registered byte-wide read port. Each 16-bit quantity is split into a high byte and a low byte.

The block leaves reset stopped, with the channel idle and the pin released. Software sets the limit, the channel mode and the channel value. It then writes any byte to the counter, which restarts the count from zero and reloads the channel output. Last, it gives the counter a nonzero clock select. That step starts counting and hands the pin to the timer.

Top module: `edge_pwm_timer`

## Requirements
- R1: After reset, the clock select (address 0, bits [1:0]) reads 00 and the counter reads 0. While the clock select is 00, the counter holds its value. While it is nonzero, the counter advances once per clock.
- R2: After reset, the channel setup byte (address 7) reads 0x00, which selects input capture with edge/level 00. At the same time `ch_out` is 0 and `ch_oe` is 0.
- R3: A write of any data to counter address 1 (high byte) or address 2 (low byte) loads the counter with 0x0000. Reads of addresses 1 and 2 return the counter's high and low bytes.
- R4: The same counter write sets `ch_out` to its mode's initial level: 1 in PWM mode and 0 in capture mode. In compare mode, `ch_out` keeps its value.
- R5: `ch_oe` is 1 only when the clock select is nonzero, the edge/level field is nonzero and the channel is in compare or PWM mode. While `ch_oe` is 0, `ch_out` keeps its last value.
- R6: With a nonzero clock select, the counter runs 0, 1, ... up to the limit (addresses 3 high and 4 low), then returns to 0 on the next clock.
- R7: In PWM mode (setup bits [1:0] = 10, bits [3:2] nonzero), `ch_out` rises on the clock where the counter is 0 and falls on the clock where the counter equals the channel value (addresses 5 high and 6 low). For 0 < value < limit, the output is high for `value` clocks in each period of limit+1 clocks.
- R8: In compare mode (setup bits [1:0] = 01, bits [3:2] nonzero), `ch_out` inverts on every running clock where the counter equals the channel value.
- R9: In capture mode (bits [1:0] = 00), bits [3:2] select the capture edge: 01 rising, 10 falling, 11 both. The input passes through a two-stage synchronizer. The counter value present at the third clock after the input changes is loaded into the channel value. An edge that is not selected leaves the channel value unchanged.
- R10: Writes to the limit and channel value registers are staged per byte. The new 16-bit value takes effect only once both bytes have been written, in either order. Until then, reads return the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 8 | Read data, registered one clock after `rd_addr` |
| cap_in | input | 1 | Asynchronous capture input |
| ch_out | output | 1 | Channel output level |
| ch_oe | output | 1 | Channel output enable, high when the timer owns the pin |

## Verification
The PWM waveform is checked clock by clock for a limit of 9 and a value of 5. This shows whether the rising edge comes at counter zero and the falling edge at the match, and whether the wrap happens at the limit or one clock off. Compare toggling runs through several wraps at a value of 3, which shows a toggle repeating every period rather than firing only once. A mid-period counter write in PWM mode and a counter write in compare mode separate a reload to the initial level from a hold. The capture runs use a rising edge, then an unselected edge, then a falling edge, so that the exact capture latency and the edge filtering are both seen through the channel value readback. The byte-staging runs write the two halves in both orders and read back between the two writes.

// File: rtl/ept_pkg.sv
package ept_pkg;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_CTRL  = 3'd0;
  localparam logic [ADDR_W-1:0] A_CNT_H = 3'd1;
  localparam logic [ADDR_W-1:0] A_CNT_L = 3'd2;
  localparam logic [ADDR_W-1:0] A_LIM_H = 3'd3;
  localparam logic [ADDR_W-1:0] A_LIM_L = 3'd4;
  localparam logic [ADDR_W-1:0] A_VAL_H = 3'd5;
  localparam logic [ADDR_W-1:0] A_VAL_L = 3'd6;
  localparam logic [ADDR_W-1:0] A_SETUP = 3'd7;

  typedef enum logic [1:0] {
    CH_CAPT = 2'b00,
    CH_CMP  = 2'b01,
    CH_PWM  = 2'b10,
    CH_RSVD = 2'b11
  } ch_mode_e;

  function automatic logic drives_pin(ch_mode_e m);
    return (m == CH_CMP) || (m == CH_PWM);
  endfunction
endpackage

// File: rtl/ept_pair.sv
module ept_pair #(
  parameter int BW = 8,
  localparam int W = 2 * BW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hi_we,
  input  logic          lo_we,
  input  logic [BW-1:0] wdata,
  input  logic          ld,
  input  logic [W-1:0]  ld_val,
  output logic [W-1:0]  val
);
  logic [BW-1:0] hbuf, lbuf, hnew, lnew;
  logic          hseen, lseen, commit;

  always_comb begin
    hnew   = hi_we ? wdata : hbuf;
    lnew   = lo_we ? wdata : lbuf;
    commit = (hi_we && (lseen || lo_we)) || (lo_we && hseen);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hbuf  <= '0;
      lbuf  <= '0;
      hseen <= 1'b0;
      lseen <= 1'b0;
      val   <= '0;
    end else begin
      if (hi_we) hbuf <= wdata;
      if (lo_we) lbuf <= wdata;
      if (commit) begin
        hseen <= 1'b0;
        lseen <= 1'b0;
      end else begin
        if (hi_we) hseen <= 1'b1;
        if (lo_we) lseen <= 1'b1;
      end
      if (commit)  val <= {hnew, lnew};
      else if (ld) val <= ld_val;
    end
  end
endmodule

// File: rtl/ept_regs.sv
module ept_regs
  import ept_pkg::*;
#(
  parameter int BW = 8,
  localparam int W = 2 * BW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BW-1:0]     wr_data,
  input  logic              cap_ld,
  input  logic [W-1:0]      cap_val,
  output logic [1:0]        clk_sel,
  output ch_mode_e          mode,
  output logic [1:0]        els,
  output logic [W-1:0]      lim_val,
  output logic [W-1:0]      chv_val,
  output logic              cnt_clr
);
  localparam int NPAIR = 2;

  logic [W-1:0] pv [NPAIR];
  logic [3:0]   setup_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      clk_sel <= 2'b00;
      setup_q <= 4'h0;
    end else if (wr_en) begin
      if (wr_addr == A_CTRL)  clk_sel <= wr_data[1:0];
      if (wr_addr == A_SETUP) setup_q <= wr_data[3:0];
    end
  end

  genvar g;
  generate
    for (g = 0; g < NPAIR; g++) begin : g_pair
      localparam logic [ADDR_W-1:0] HI = ADDR_W'(A_LIM_H + 2 * g);
      localparam logic [ADDR_W-1:0] LO = ADDR_W'(A_LIM_H + 2 * g + 1);
      ept_pair #(.BW(BW)) u_pair (
        .clk    (clk),
        .rst    (rst),
        .hi_we  (wr_en && (wr_addr == HI)),
        .lo_we  (wr_en && (wr_addr == LO)),
        .wdata  (wr_data),
        .ld     ((g == 1) ? cap_ld : 1'b0),
        .ld_val (cap_val),
        .val    (pv[g])
      );
    end
  endgenerate

  always_comb begin
    lim_val = pv[0];
    chv_val = pv[1];
    mode    = ch_mode_e'(setup_q[1:0]);
    els     = setup_q[3:2];
    cnt_clr = wr_en && ((wr_addr == A_CNT_H) || (wr_addr == A_CNT_L));
  end
endmodule

// File: rtl/ept_count.sv
module ept_count #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         clr,
  input  logic [W-1:0] lim,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst)      cnt <= '0;
    else if (clr) cnt <= '0;
    else if (en)  cnt <= (cnt >= lim) ? '0 : cnt + 1'b1;
  end
endmodule

// File: rtl/ept_chan.sv
module ept_chan
  import ept_pkg::*;
#(
  parameter int W = 16,
  parameter int SYNC = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         clr,
  input  ch_mode_e     mode,
  input  logic [1:0]   els,
  input  logic [W-1:0] cnt,
  input  logic [W-1:0] chv,
  input  logic         cap_in,
  output logic         ch_out,
  output logic         cap_ld
);
  logic [SYNC-1:0] sync_q;
  logic            prev_q, rise, fall, hit, act, is_capt;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC-2:0], cap_in};
      prev_q <= sync_q[SYNC-1];
    end
  end

  always_comb begin
    rise    = sync_q[SYNC-1] && !prev_q;
    fall    = !sync_q[SYNC-1] && prev_q;
    hit     = (els[0] && rise) || (els[1] && fall);
    act     = en && (els != 2'b00);
    is_capt = !drives_pin(mode);
    cap_ld  = act && is_capt && hit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ch_out <= 1'b0;
    end else if (clr) begin
      if (mode == CH_PWM)      ch_out <= 1'b1;
      else if (mode != CH_CMP) ch_out <= 1'b0;
    end else if (act) begin
      case (mode)
        CH_CMP: if (cnt == chv) ch_out <= ~ch_out;
        CH_PWM: begin
          if (cnt == chv)     ch_out <= 1'b0;
          else if (cnt == '0) ch_out <= 1'b1;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/edge_pwm_timer.sv
module edge_pwm_timer
  import ept_pkg::*;
#(
  parameter int BW = 8,
  localparam int W = 2 * BW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BW-1:0]     wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [BW-1:0]     rd_data,
  input  logic              cap_in,
  output logic              ch_out,
  output logic              ch_oe
);
  logic [1:0]   clk_sel, els;
  ch_mode_e     mode;
  logic [W-1:0] lim_val, chv_val, cnt;
  logic         cnt_clr, cap_ld, run;

  assign run = (clk_sel != 2'b00);

  ept_regs #(.BW(BW)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .cap_ld  (cap_ld),
    .cap_val (cnt),
    .clk_sel (clk_sel),
    .mode    (mode),
    .els     (els),
    .lim_val (lim_val),
    .chv_val (chv_val),
    .cnt_clr (cnt_clr)
  );

  ept_count #(.W(W)) u_count (
    .clk (clk),
    .rst (rst),
    .en  (run),
    .clr (cnt_clr),
    .lim (lim_val),
    .cnt (cnt)
  );

  ept_chan #(.W(W)) u_chan (
    .clk    (clk),
    .rst    (rst),
    .en     (run),
    .clr    (cnt_clr),
    .mode   (mode),
    .els    (els),
    .cnt    (cnt),
    .chv    (chv_val),
    .cap_in (cap_in),
    .ch_out (ch_out),
    .cap_ld (cap_ld)
  );

  assign ch_oe = run && (els != 2'b00) && drives_pin(mode);

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else begin
      case (rd_addr)
        A_CTRL:  rd_data <= BW'(clk_sel);
        A_CNT_H: rd_data <= cnt[W-1:BW];
        A_CNT_L: rd_data <= cnt[BW-1:0];
        A_LIM_H: rd_data <= lim_val[W-1:BW];
        A_LIM_L: rd_data <= lim_val[BW-1:0];
        A_VAL_H: rd_data <= chv_val[W-1:BW];
        A_VAL_L: rd_data <= chv_val[BW-1:0];
        default: rd_data <= BW'({els, mode});
      endcase
    end
  end
endmodule

// File: rtl/ept_chk.sv
module ept_chk
  import ept_pkg::*;
#(
  parameter int W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              ch_out,
  input logic              ch_oe,
  input logic [1:0]        clk_sel,
  input logic [1:0]        els,
  input ch_mode_e          mode,
  input logic [W-1:0]      cnt,
  input logic [W-1:0]      lim_val,
  input logic [W-1:0]      chv_val
);
  logic cw, running;
  assign cw      = wr_en && ((wr_addr == A_CNT_H) || (wr_addr == A_CNT_L));
  assign running = (clk_sel != 2'b00);

  assert_stopped_R1: assert property (@(posedge clk) disable iff (rst)
    (!running && !cw) |=> $stable(cnt));

  assert_clear_R3: assert property (@(posedge clk) disable iff (rst)
    cw |=> (cnt == '0));

  assert_pwm_init_R4: assert property (@(posedge clk) disable iff (rst)
    (cw && mode == CH_PWM) |=> ch_out);

  assert_cmp_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (cw && mode == CH_CMP) |=> $stable(ch_out));

  assert_oe_owner_R5: assert property (@(posedge clk) disable iff (rst)
    ch_oe |-> (running && els != 2'b00 && mode != CH_CAPT));

  assert_wrap_R6: assert property (@(posedge clk) disable iff (rst)
    (running && !cw && cnt == lim_val) |=> (cnt == '0));

  assert_step_R6: assert property (@(posedge clk) disable iff (rst)
    (running && !cw && cnt < lim_val) |=> (cnt == W'($past(cnt) + 1'b1)));

  assert_pwm_fall_R7: assert property (@(posedge clk) disable iff (rst)
    (running && !cw && els != 2'b00 && mode == CH_PWM && cnt == chv_val
     && chv_val != '0) |=> !ch_out);
endmodule

bind edge_pwm_timer ept_chk #(.W(W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .wr_en   (wr_en),
  .wr_addr (wr_addr),
  .ch_out  (ch_out),
  .ch_oe   (ch_oe),
  .clk_sel (clk_sel),
  .els     (els),
  .mode    (mode),
  .cnt     (cnt),
  .lim_val (lim_val),
  .chv_val (chv_val)
);

// File: tb/sim_edge_pwm_timer.sv
module sim_edge_pwm_timer;
  import ept_pkg::*;

  logic       clk = 1'b0, rst = 1'b1, wr_en = 1'b0, cap_in = 1'b0;
  logic [2:0] wr_addr = '0, rd_addr = '0;
  logic [7:0] wr_data = '0;
  wire  [7:0] rd_data;
  wire        ch_out, ch_oe;

  int errors = 0, checks = 0, cyc = 0;
  bit done = 0;

  typedef struct { int at; int exp; string req; } item_t;
  item_t q[$];

  always #4 clk = ~clk;

  edge_pwm_timer u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .cap_in(cap_in),
    .ch_out(ch_out), .ch_oe(ch_oe)
  );

  task automatic chk(string req, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // monitor: pops scheduled expectations of ch_out
  always @(posedge clk) begin
    #2;
    cyc++;
    while (q.size() > 0 && q[0].at <= cyc) begin
      item_t it;
      it = q.pop_front();
      chk(it.req, int'(ch_out), it.exp, "ch_out");
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output int d);
    @(negedge clk);
    rd_addr = a;
    @(posedge clk);
    #2;
    d = int'(rd_data);
  endtask

  task automatic push_pwm(int n, int lim, int val, int base, string req);
    for (int k = 1; k <= n; k++) begin
      item_t it;
      it.at = base + k; it.exp = (((k - 1) % (lim + 1)) < val) ? 1 : 0; it.req = req;
      q.push_back(it);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    int v, v2, o0, base, cnt_e;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 / R2 reset state
    chk("R2", int'(ch_out), 0, "ch_out after reset");
    chk("R2", int'(ch_oe), 0, "ch_oe after reset");
    rd(A_CTRL, v);  chk("R1", v, 0, "clock select");
    rd(A_SETUP, v); chk("R2", v, 0, "setup byte");
    rd(A_CNT_L, v); chk("R1", v, 0, "counter low");
    repeat (5) @(negedge clk);
    rd(A_CNT_L, v); chk("R1", v, 0, "counter held while stopped");

    // R10 staged limit writes, both orders
    wr(A_LIM_H, 8'h12);
    rd(A_LIM_H, v); chk("R10", v, 8'h00, "limit high before pair done");
    wr(A_LIM_L, 8'h34);
    rd(A_LIM_H, v); chk("R10", v, 8'h12, "limit high after pair");
    rd(A_LIM_L, v); chk("R10", v, 8'h34, "limit low after pair");
    wr(A_LIM_L, 8'h09);
    rd(A_LIM_L, v); chk("R10", v, 8'h34, "limit low before pair done");
    wr(A_LIM_H, 8'h00);
    rd(A_LIM_L, v); chk("R10", v, 8'h09, "limit low, reverse order");
    wr(A_VAL_H, 8'h00); wr(A_VAL_L, 8'h05);

    // PWM: mode 10, edge/level 01
    wr(A_SETUP, 8'h06);
    wr(A_CNT_H, 8'hA5);
    chk("R4", int'(ch_out), 1, "PWM initial level after counter write");
    chk("R5", int'(ch_oe), 0, "pin released with clock select 00");
    wr(A_CTRL, 8'h01);
    base = cyc;
    push_pwm(30, 9, 5, base, "R7");
    repeat (31) @(negedge clk);
    chk("R5", int'(ch_oe), 1, "pin owned while running");

    // R4 mid-period counter write while output is low
    while (ch_out !== 1'b0) @(negedge clk);
    wr_en = 1'b1; wr_addr = A_CNT_L; wr_data = 8'h3C;
    @(negedge clk);
    wr_en = 1'b0;
    base = cyc;
    chk("R4", int'(ch_out), 1, "PWM reload to high on counter write");
    push_pwm(12, 9, 5, base, "R6");
    repeat (13) @(negedge clk);

    // R5 stop: pin released, output retained
    wr(A_CTRL, 8'h00);
    o0 = int'(ch_out);
    chk("R5", int'(ch_oe), 0, "pin released after stop");
    repeat (5) @(negedge clk);
    chk("R5", int'(ch_out), o0, "output retained while released");

    // compare toggle: mode 01, edge/level 01, value 3
    wr(A_SETUP, 8'h05);
    wr(A_VAL_H, 8'h00); wr(A_VAL_L, 8'h03);
    o0 = int'(ch_out);
    wr(A_CNT_L, 8'hFF);
    chk("R4", int'(ch_out), o0, "compare output kept on counter write");
    wr(A_CTRL, 8'h01);
    base = cyc;
    v = o0;
    for (int k = 1; k <= 25; k++) begin
      item_t it;
      if (((k - 1) % 10) == 3) v = v ^ 1;
      it.at = base + k; it.exp = v; it.req = "R8";
      q.push_back(it);
    end
    repeat (26) @(negedge clk);
    wr(A_CTRL, 8'h00);
    rd(A_CNT_L, v);
    repeat (4) @(negedge clk);
    rd(A_CNT_L, v2);
    chk("R1", v2, v, "counter holds after stop");
    wr(A_CNT_H, 8'h5A);
    rd(A_CNT_L, v); chk("R3", v, 0, "counter low after high-byte write");
    rd(A_CNT_H, v); chk("R3", v, 0, "counter high after high-byte write");

    // capture: mode 00, rising edge (edge/level 01)
    wr(A_SETUP, 8'h04);
    wr(A_LIM_H, 8'h00); wr(A_LIM_L, 8'hFF);
    wr(A_CNT_L, 8'h00);
    chk("R4", int'(ch_out), 0, "capture initial level");
    wr(A_CTRL, 8'h01);
    repeat (3) @(negedge clk);
    chk("R5", int'(ch_oe), 0, "capture mode never owns pin");
    wr(A_CNT_H, 8'h00);
    cap_in = 1'b1;
    cnt_e = 2;
    repeat (6) @(negedge clk);
    rd(A_VAL_L, v); chk("R9", v, cnt_e, "rising capture value");
    rd(A_VAL_H, v); chk("R9", v, 0, "rising capture high byte");
    cap_in = 1'b0;
    repeat (6) @(negedge clk);
    rd(A_VAL_L, v); chk("R9", v, cnt_e, "falling edge ignored in rising mode");

    // falling edge mode (edge/level 10)
    wr(A_VAL_H, 8'h00); wr(A_VAL_L, 8'h77);
    wr(A_SETUP, 8'h08);
    cap_in = 1'b1;
    repeat (6) @(negedge clk);
    rd(A_VAL_L, v); chk("R9", v, 8'h77, "rising edge ignored in falling mode");
    wr(A_CNT_L, 8'h11);
    cap_in = 1'b0;
    repeat (6) @(negedge clk);
    rd(A_VAL_L, v); chk("R9", v, 2, "falling capture value");

    done = 1;
    summary();
    $finish;
  end
endmodule